// File: doc/BRIEF.md
# Loop Step Counter Unit

This unit executes the two loop-control operations of a small processor core once decode has identified them. The register variant takes one register index and a 24-bit branch label. It subtracts one from that register, writes the result back, and asks for a branch to the label whenever the new value is not zero. Decrement, write-back and the branch decision therefore happen in a single operation.

The memory variant takes a register index whose contents point at a two-word loop record. The word at the pointer holds the running count. The word four bytes above it holds the end value. The unit fetches both words and writes back the count plus one. It then reports a zero flag that is set exactly when the new count equals the end value, so a later conditional jump on "not zero" repeats the loop body until the end value is reached. The counter runs upward from any start value.

Register file and memory are outside the block. The register file is reached through one combinational read port and one write port. Memory is reached through a 32-bit word port with a ready handshake. Fetch, decode and the instruction pointer are also outside. When the unit does not ask for a branch, the front end continues with the next sequential instruction.

Top module: `loop_step_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, rf_we, mem_req, flag_z_we and branch_req are all 0.
- R2: A start with op_mem=0 leads, one cycle later, to a single cycle with done=1, rf_we=1, rf_waddr equal to the captured reg_sel, and rf_wdata equal to the register's value minus one. The subtraction is modulo 2^32, so 0 becomes 0xFFFFFFFF.
- R3: In the register variant, branch_req=1 with branch_target equal to the captured label when the decremented value is nonzero. branch_req stays 0 when the decremented value is zero.
- R4: The register variant makes no memory access and never asserts flag_z_we.
- R5: With op_mem=1, the unit issues exactly three accesses in this order: a read of address ptr, a read of address ptr+4, and a write of address ptr. Here ptr is the low 24 bits of the pointer register, and addresses wrap modulo 2^24. Each access holds mem_req, mem_we and mem_addr unchanged until mem_ready is seen.
- R6: The memory variant writes back the count read at ptr plus one, modulo 2^32. In its done cycle it asserts flag_z_we=1 with flag_z=1 when that new count equals the end value read at ptr+4, and flag_z=0 otherwise. It never asserts rf_we or branch_req.
- R7: A start that arrives while busy=1 is ignored. It causes no register write and no extra memory access, and the unit returns to busy=0 in the cycle after done.
- R8: A memory count of 0xFFFFFFFF steps to 0. An end value of 0 then produces flag_z=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; only taken when idle |
| op_mem | input | 1 | 1 selects the memory variant, 0 the register variant |
| reg_sel | input | 3 | Counter register (register variant) or pointer register (memory variant) |
| label | input | 24 | Branch target for the register variant |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 32 | Register file read data, combinational |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| flag_z_we | output | 1 | Zero-flag write strobe |
| flag_z | output | 1 | New zero-flag value |
| branch_req | output | 1 | Redirect fetch to branch_target |
| branch_target | output | 24 | Branch destination |

## Verification
A corrupted pointer latch shows up as wrong addresses from the first access onward. The access log exposes it about three cycles after start. A count or end register that captures the wrong value is only visible later: it shows at the write-back data and in the zero-flag value of the done cycle, which comes at least six cycles after start. A sequencer that leaves its idle state at the wrong time shows as an unexpected register write, an extra memory access, or busy still high one cycle after done. The bench checks the ports in that cycle.

// File: rtl/loop_step_pkg.sv
package loop_step_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DEC    = 3'd1,
    ST_PTR    = 3'd2,
    ST_RD_CNT = 3'd3,
    ST_RD_END = 3'd4,
    ST_WR_CNT = 3'd5,
    ST_FIN    = 3'd6
  } step_state_t;
endpackage

// File: rtl/loop_step_fsm.sv
module loop_step_fsm
  import loop_step_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_mem,
  input  logic        mem_ready,
  output step_state_t state
);
  step_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = op_mem ? ST_PTR : ST_DEC;
      ST_DEC:    nxt = ST_IDLE;
      ST_PTR:    nxt = ST_RD_CNT;
      ST_RD_CNT: if (mem_ready) nxt = ST_RD_END;
      ST_RD_END: if (mem_ready) nxt = ST_WR_CNT;
      ST_WR_CNT: if (mem_ready) nxt = ST_FIN;
      ST_FIN:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/loop_step_dp.sv
module loop_step_dp #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 24,
  parameter int IDX_W   = 3,
  parameter int END_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              in_dec,
  input  logic              in_ptr,
  input  logic              in_rd_cnt,
  input  logic              in_rd_end,
  input  logic              in_wr_cnt,
  input  logic              in_fin,
  input  logic              mem_ready,
  input  logic [IDX_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] label,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_raddr,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flag_z_we,
  output logic              flag_z,
  output logic              branch_req,
  output logic [ADDR_W-1:0] branch_target,
  output logic              dec_nonzero
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(END_OFS);

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] v);
    return v - DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] step_up(input logic [DATA_W-1:0] v);
    return v + DATA_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] end_addr(input logic [ADDR_W-1:0] p);
    return p + OFS;
  endfunction

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] label_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] end_q;
  logic [DATA_W-1:0] dec_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      label_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      end_q   <= '0;
    end else begin
      if (ev_accept) begin
        idx_q   <= reg_sel;
        label_q <= label;
      end
      if (in_ptr)                 ptr_q <= rf_rdata[ADDR_W-1:0];
      if (in_rd_cnt && mem_ready) cnt_q <= step_up(mem_rdata);
      if (in_rd_end && mem_ready) end_q <= mem_rdata;
    end
  end

  assign dec_val       = step_down(rf_rdata);
  assign dec_nonzero   = (dec_val != '0);

  assign rf_raddr      = idx_q;
  assign rf_waddr      = idx_q;
  assign rf_we         = in_dec;
  assign rf_wdata      = dec_val;

  assign branch_req    = in_dec && dec_nonzero;
  assign branch_target = label_q;

  assign mem_req       = in_rd_cnt | in_rd_end | in_wr_cnt;
  assign mem_we        = in_wr_cnt;
  assign mem_addr      = in_rd_end ? end_addr(ptr_q) : ptr_q;
  assign mem_wdata     = cnt_q;

  assign flag_z_we     = in_fin;
  assign flag_z        = in_fin && (cnt_q == end_q);
endmodule

// File: rtl/loop_step_unit.sv
module loop_step_unit
  import loop_step_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 24,
  parameter int REG_CNT = 8,
  parameter int END_OFS = 4,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_mem,
  input  logic [IDX_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] label,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              flag_z_we,
  output logic              flag_z,
  output logic              branch_req,
  output logic [ADDR_W-1:0] branch_target
);
  step_state_t state;

  logic ev_accept;
  logic in_dec, in_ptr, in_rd_cnt, in_rd_end, in_wr_cnt, in_fin;
  logic dec_nonzero;

  loop_step_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_mem    (op_mem),
    .mem_ready (mem_ready),
    .state     (state)
  );

  assign ev_accept = (state == ST_IDLE) && start;
  assign in_dec    = (state == ST_DEC);
  assign in_ptr    = (state == ST_PTR);
  assign in_rd_cnt = (state == ST_RD_CNT);
  assign in_rd_end = (state == ST_RD_END);
  assign in_wr_cnt = (state == ST_WR_CNT);
  assign in_fin    = (state == ST_FIN);

  assign busy = (state != ST_IDLE);
  assign done = in_dec | in_fin;

  loop_step_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .END_OFS (END_OFS)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_accept     (ev_accept),
    .in_dec        (in_dec),
    .in_ptr        (in_ptr),
    .in_rd_cnt     (in_rd_cnt),
    .in_rd_end     (in_rd_end),
    .in_wr_cnt     (in_wr_cnt),
    .in_fin        (in_fin),
    .mem_ready     (mem_ready),
    .reg_sel       (reg_sel),
    .label         (label),
    .rf_rdata      (rf_rdata),
    .mem_rdata     (mem_rdata),
    .rf_raddr      (rf_raddr),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .rf_wdata      (rf_wdata),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .flag_z_we     (flag_z_we),
    .flag_z        (flag_z),
    .branch_req    (branch_req),
    .branch_target (branch_target),
    .dec_nonzero   (dec_nonzero)
  );
endmodule

// File: rtl/loop_step_chk.sv
module loop_step_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_accept,
  input logic              op_mem,
  input logic              busy,
  input logic              done,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              flag_z_we,
  input logic              branch_req
);
  // R2
  reg_op_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !op_mem |=> rf_we && done);

  // R3
  branch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_req |-> rf_we && (rf_wdata != '0));

  // R4
  reg_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req && !flag_z_we);

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  mem_flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z_we |-> !rf_we && !branch_req && !mem_req && done);

  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind loop_step_unit loop_step_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_accept  (ev_accept),
  .op_mem     (op_mem),
  .busy       (busy),
  .done       (done),
  .rf_we      (rf_we),
  .rf_wdata   (rf_wdata),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ready  (mem_ready),
  .flag_z_we  (flag_z_we),
  .branch_req (branch_req)
);

// File: tb/sim_loop_step_unit.sv
`timescale 1ns/1ps
module sim_loop_step_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, op_mem = 0;
  logic [2:0]  reg_sel = 0;
  logic [23:0] label = 0;
  logic        busy, done, rf_we, mem_req, mem_we, flag_z_we, flag_z, branch_req;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        mem_ready = 0;
  logic [23:0] mem_addr, branch_target;

  always #2.5 clk = ~clk;

  loop_step_unit u0 (.*);

  logic [31:0] rf [0:7];
  logic [31:0] mem [0:15];
  logic [23:0] log_addr [0:7];
  logic        log_we [0:7];
  int          log_n = 0;
  int          wait_cfg = 0;
  int          wcnt = 0;
  int          memreq_cnt = 0;
  int          cyc = 0;
  int          checks = 0, errors = 0;

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req) memreq_cnt <= memreq_cnt + 1;
    mem_ready <= 1'b0;
    if (mem_req && !mem_ready) begin
      if (wcnt >= wait_cfg) begin
        mem_ready <= 1'b1;
        wcnt <= 0;
        if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[5:2]];
        if (log_n < 8) begin
          log_addr[log_n] <= mem_addr;
          log_we[log_n]   <= mem_we;
        end
        log_n <= log_n + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // captured at the done cycle
  logic        c_br, c_zwe, c_z, c_we;
  logic [31:0] c_wd;
  logic [2:0]  c_wa;
  logic [23:0] c_bt;
  int          c_lat;

  task automatic run_op(input bit m, input logic [2:0] sel, input logic [23:0] lab);
    @(negedge clk);
    start = 1; op_mem = m; reg_sel = sel; label = lab;
    @(negedge clk);
    start = 0;
    c_lat = 1;
    while (!done && c_lat < 200) begin
      @(negedge clk);
      c_lat++;
    end
    c_br = branch_req; c_zwe = flag_z_we; c_z = flag_z; c_we = rf_we;
    c_wd = rf_wdata; c_wa = rf_waddr; c_bt = branch_target;
    @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam logic        V_MEM [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_A   [0:NV-1] = '{32'd5, 32'd1, 32'd0, 32'd9, 32'd3, 32'hFFFF_FFFF};
  localparam logic [31:0] V_B   [0:NV-1] = '{32'h0, 32'h0, 32'h0, 32'd10, 32'd10, 32'd0};
  localparam int          V_W   [0:NV-1] = '{0, 0, 0, 0, 2, 1};

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk({busy, done, rf_we, mem_req, flag_z_we, branch_req} == 6'b0, "R1 in reset",
        {26'd0, busy, done, rf_we, mem_req, flag_z_we, branch_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, rf_we, mem_req, flag_z_we, branch_req} == 6'b0, "R1 after reset",
        {26'd0, busy, done, rf_we, mem_req, flag_z_we, branch_req}, 0);

    for (int v = 0; v < NV; v++) begin
      wait_cfg = V_W[v];
      if (!V_MEM[v]) begin
        logic [31:0] e;
        rf[3] = V_A[v];
        e = V_A[v] - 32'd1;
        memreq_cnt = 0;
        run_op(1'b0, 3'd3, 24'h00_1230 + 24'(v));
        chk(c_lat == 1, "R2 latency", 32'(c_lat), 1);
        chk(c_we && c_wa == 3'd3 && c_wd == e, "R2 write", c_wd, e);
        chk(rf[3] == e, "R2 register value", rf[3], e);
        chk(c_br == (e != 0), "R3 branch request", {31'd0, c_br}, {31'd0, e != 0});
        if (e != 0) chk(c_bt == 24'h00_1230 + 24'(v), "R3 target", {8'd0, c_bt}, {8'd0, 24'h00_1230 + 24'(v)});
        chk(!c_zwe && memreq_cnt == 0, "R4 no flag/memory", 32'(memreq_cnt), 0);
      end else begin
        logic [31:0] nc;
        rf[5] = 32'h0000_0040;
        mem[0] = V_A[v];
        mem[1] = V_B[v];
        nc = V_A[v] + 32'd1;
        log_n = 0;
        run_op(1'b1, 3'd5, 24'h0);
        chk(log_n == 3, "R5 access count", 32'(log_n), 3);
        chk(log_addr[0] == 24'h40 && !log_we[0], "R5 first read ptr", {8'd0, log_addr[0]}, 32'h40);
        chk(log_addr[1] == 24'h44 && !log_we[1], "R5 second read ptr+4", {8'd0, log_addr[1]}, 32'h44);
        chk(log_addr[2] == 24'h40 && log_we[2], "R5 write ptr", {8'd0, log_addr[2]}, 32'h40);
        chk(mem[0] == nc, "R6 written count", mem[0], nc);
        chk(c_zwe && c_z == (nc == V_B[v]), "R6 zero flag", {30'd0, c_zwe, c_z}, {30'd0, 1'b1, nc == V_B[v]});
        chk(!c_we && !c_br, "R6 no reg write/branch", {30'd0, c_we, c_br}, 0);
        if (V_A[v] == 32'hFFFF_FFFF) chk(mem[0] == 0 && c_z, "R8 count wrap", mem[0], 0);
      end
    end

    // R5 pointer wrap: ptr 0xFFFFFC -> end word at 0x000000
    wait_cfg = 0;
    rf[2] = 32'h00FF_FFFC;
    mem[15] = 32'd7;
    mem[0]  = 32'd8;
    log_n = 0;
    run_op(1'b1, 3'd2, 24'h0);
    chk(log_addr[1] == 24'h0, "R5 address wrap", {8'd0, log_addr[1]}, 0);
    chk(c_z && mem[15] == 32'd8, "R6 wrap record", mem[15], 8);

    // R7 start while busy is ignored
    wait_cfg = 3;
    rf[5] = 32'h0000_0040;
    rf[3] = 32'd20;
    mem[0] = 32'd1; mem[1] = 32'd5;
    log_n = 0;
    @(negedge clk);
    start = 1; op_mem = 1; reg_sel = 3'd5;
    @(negedge clk);
    op_mem = 0; reg_sel = 3'd3;
    repeat (4) @(negedge clk);
    start = 0;
    c_lat = 0;
    while (!done && c_lat < 200) begin
      @(negedge clk);
      c_lat++;
    end
    chk(!rf_we && flag_z_we && !flag_z, "R7 memory op completes", {31'd0, flag_z}, 0);
    @(negedge clk);
    chk(!busy, "R7 idle after done", {31'd0, busy}, 0);
    chk(log_n == 3 && rf[3] == 32'd20, "R7 no extra work", 32'(log_n), 3);
    chk(mem[0] == 32'd2, "R6 count after stall", mem[0], 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule